// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is an 8-bit timer/counter with a single output compare channel. The counter advances only on cycles where a one-cycle tick enable is high. It compares the count against an active compare value and drives one waveform output and a sticky compare match flag. A simple write port loads the counter, the compare value, a control field, a force strobe and a flag-clear strobe.

Four waveform modes are supported:
- a free-running count;
- a clear-on-match count, whose period is the compare value plus one;
- fast PWM, which counts up only;
- phase-correct PWM, which counts up and then down.

In both PWM modes the compare value is staged in a buffer and reaches the comparator only at the top of the count. This keeps each PWM period whole.

Writing the counter masks compare matches on the following tick, so software can preload equal count and compare values without a spurious event. A force strobe applies the channel's pin action in the non-PWM modes without touching the flag or the count.

Top module: `tmrCompare`

## Requirements
- R1: After reset, the counter, the compare value, its buffer, the control field, the flag and the pin register are all zero, so `cntVal`, `wavePin` and `cmpFlag` read 0.
- R2: The counter changes only on a tick or a counter write. In normal mode (mode 00) each tick adds one, and 255 wraps to 0.
- R3: A tick on which the count equals the active compare value, and which is not masked, sets `cmpFlag`. A write of data bit 0 = 1 to address 4 clears it, and a write with bit 0 = 0 leaves it unchanged.
- R4: In clear-on-match mode (mode 01), a match tick loads 0 into the counter, so the count runs 0..K with period K+1.
- R5: In the non-PWM modes, the 2-bit output action `com` selects what a match does: 01 toggles the pin register, 10 clears it, 11 sets it, and 00 disconnects the pin (the pin reads 0 and the register is untouched). In the PWM modes, `com` 00 and 01 disconnect the pin.
- R6: A compare write (address 1) goes straight to the active compare value in the non-PWM modes. In the PWM modes it goes only to the buffer, which is copied to the active value on the tick taken at count 255.
- R7: A force write (address 3, data bit 0 = 1) in a non-PWM mode applies the `com` action to the pin register. It does not set the flag and does not change the count. In the PWM modes it has no effect.
- R8: A counter write (address 0) masks every compare match on the next tick, however many idle cycles pass before that tick.
- R9: Fast PWM (mode 10) counts 0..255 and wraps. With `com` = 10, the pin is set on the wrap tick and cleared on a match, so it is high for K+1 of every 256 ticks (256 when K = 255). With `com` = 11 the output is inverted: high for 255-K ticks (0 when K = 255).
- R10: Phase-correct PWM (mode 11) counts 0 up to 255 and back down to 0, a period of 510 ticks. After the tick at 255 the count is 254. With `com` = 10, a match while counting up clears the pin and a match while counting down sets it; a match at 255 counts as downward and a match at 0 counts as upward. This gives 2K high ticks per period, and 510-2K with `com` = 11.
- R11: A change of waveform mode leaves the pin register as it was.
- R12: The control write (address 2) takes `com` from data bits 1:0 and the mode from bits 3:2. The new `com` drives the pin from the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle timer tick enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0 count, 1 compare, 2 control, 3 force, 4 flag clear |
| wrData | input | CNT_W | Write data |
| wavePin | output | 1 | Waveform output level |
| cmpFlag | output | 1 | Compare match flag |
| cntVal | output | CNT_W | Current count |

## Verification
On every cycle, the assertions check these properties:
- the counter holds between ticks and writes;
- the flag rises only after an unmasked equal-count tick;
- a clear-on-match hit zeroes the count;
- the active compare value stays frozen between top ticks in the PWM modes;
- a force in a PWM mode leaves the pin alone;
- phase-correct counting turns at the top.

Only the bench scenarios can show the behaviours that span many cycles:
- the duty cycles over a sweep of compare values in both PWM modes;
- the effect of a buffered compare write on the next period;
- the masking of a match after a counter write with a stopped timer;
- the pin register surviving mode and output-action changes.

// File: rtl/tmrPkg.sv
package tmrPkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_CTC    = 2'b01,
    MODE_FAST   = 2'b10,
    MODE_PHASE  = 2'b11
  } wgMode_e;

  localparam logic [2:0] ADDR_CNT   = 3'd0;
  localparam logic [2:0] ADDR_OCR   = 3'd1;
  localparam logic [2:0] ADDR_CTRL  = 3'd2;
  localparam logic [2:0] ADDR_FORCE = 3'd3;
  localparam logic [2:0] ADDR_FLAG  = 3'd4;

  typedef struct packed {
    logic cntLoad;
    logic cntClear;
    logic cntInc;
    logic cntDec;
    logic dirToUp;
    logic dirToDown;
    logic ocrWrite;
    logic bufWrite;
    logic bufToOcr;
    logic flagSet;
    logic flagClr;
    logic pinSet;
    logic pinClr;
    logic pinTog;
  } dpStrobe_t;
endpackage

// File: rtl/tmrDatapath.sv
module tmrDatapath
  import tmrPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] ocr,
  output logic             isMatch,
  output logic             atTop,
  output logic             atBottom,
  output logic             dirUp,
  output logic             flag,
  output logic             ocLevel
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] ocrBuf;

  // Counter and count direction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      dirUp <= 1'b1;
    end else begin
      if (stb.cntLoad)       cnt <= wrData;
      else if (stb.cntClear) cnt <= '0;
      else if (stb.cntInc)   cnt <= cnt + CNT_ONE;
      else if (stb.cntDec)   cnt <= cnt - CNT_ONE;
      if (stb.dirToDown)     dirUp <= 1'b0;
      else if (stb.dirToUp)  dirUp <= 1'b1;
    end
  end

  // Compare value and its staging buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ocr    <= '0;
      ocrBuf <= '0;
    end else begin
      if (stb.bufWrite)      ocrBuf <= wrData;
      if (stb.ocrWrite)      ocr    <= wrData;
      else if (stb.bufToOcr) ocr    <= ocrBuf;
    end
  end

  // Match flag and pin register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag    <= 1'b0;
      ocLevel <= 1'b0;
    end else begin
      if (stb.flagSet)      flag <= 1'b1;
      else if (stb.flagClr) flag <= 1'b0;
      if (stb.pinSet)       ocLevel <= 1'b1;
      else if (stb.pinClr)  ocLevel <= 1'b0;
      else if (stb.pinTog)  ocLevel <= ~ocLevel;
    end
  end

  assign isMatch  = (cnt == ocr);
  assign atTop    = (cnt == CNT_MAX);
  assign atBottom = (cnt == '0);
endmodule

// File: rtl/tmrCtrl.sv
module tmrCtrl
  import tmrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [3:0] ctlBits,
  input  logic       isMatch,
  input  logic       atTop,
  input  logic       atBottom,
  input  logic       dirUp,
  output dpStrobe_t  stb,
  output wgMode_e    mode,
  output logic [1:0] com,
  output logic       blocked,
  output logic       pinEnable
);
  logic cntWr, ocrWr, ctrlWr, forceWr, flagClrWr;
  logic pwm, stepOk, realMatch, nonInv, upPhase;

  assign cntWr     = wrEn && (wrAddr == ADDR_CNT);
  assign ocrWr     = wrEn && (wrAddr == ADDR_OCR);
  assign ctrlWr    = wrEn && (wrAddr == ADDR_CTRL);
  assign forceWr   = wrEn && (wrAddr == ADDR_FORCE) && ctlBits[0];
  assign flagClrWr = wrEn && (wrAddr == ADDR_FLAG) && ctlBits[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= MODE_NORMAL;
      com     <= 2'b00;
      blocked <= 1'b0;
    end else begin
      if (ctrlWr) begin
        mode <= wgMode_e'(ctlBits[3:2]);
        com  <= ctlBits[1:0];
      end
      if (cntWr)       blocked <= 1'b1;
      else if (tickEn) blocked <= 1'b0;
    end
  end

  assign pwm       = mode[1];
  assign stepOk    = tickEn && !cntWr;
  assign realMatch = stepOk && isMatch && !blocked;
  assign nonInv    = (com == 2'b10);
  assign upPhase   = atBottom || (dirUp && !atTop);
  assign pinEnable = (com != 2'b00) && !(pwm && com == 2'b01);

  always_comb begin
    stb          = '0;
    stb.cntLoad  = cntWr;
    stb.bufWrite = ocrWr;
    stb.ocrWrite = ocrWr && !pwm;
    stb.bufToOcr = stepOk && pwm && atTop;
    stb.flagSet  = realMatch;
    stb.flagClr  = flagClrWr;
    if (stepOk) begin
      unique case (mode)
        MODE_CTC: begin
          if (realMatch) stb.cntClear = 1'b1;
          else           stb.cntInc   = 1'b1;
        end
        MODE_PHASE: begin
          if (upPhase) stb.cntInc = 1'b1;
          else         stb.cntDec = 1'b1;
          stb.dirToDown = atTop;
          stb.dirToUp   = atBottom;
        end
        default: stb.cntInc = 1'b1;
      endcase
    end
    unique case (mode)
      MODE_NORMAL, MODE_CTC: begin
        if (realMatch || forceWr) begin
          stb.pinTog = (com == 2'b01);
          stb.pinClr = (com == 2'b10);
          stb.pinSet = (com == 2'b11);
        end
      end
      MODE_FAST: begin
        if (com[1]) begin
          if (stepOk && atTop) begin
            stb.pinSet = nonInv;
            stb.pinClr = !nonInv;
          end else if (realMatch) begin
            stb.pinClr = nonInv;
            stb.pinSet = !nonInv;
          end
        end
      end
      default: begin
        if (com[1] && realMatch) begin
          stb.pinClr = (upPhase == nonInv);
          stb.pinSet = (upPhase != nonInv);
        end
      end
    endcase
  end
endmodule

// File: rtl/tmrCompare.sv
module tmrCompare
  import tmrPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic             wavePin,
  output logic             cmpFlag,
  output logic [CNT_W-1:0] cntVal
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_TURN = CNT_MAX - CNT_W'(1);

  dpStrobe_t        stb;
  wgMode_e          mode;
  logic [1:0]       com;
  logic             blocked, pinEnable;
  logic             isMatch, atTop, atBottom, dirUp, ocLevel;
  logic [CNT_W-1:0] ocrVal;

  tmrCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .ctlBits(wrData[3:0]), .isMatch(isMatch), .atTop(atTop),
    .atBottom(atBottom), .dirUp(dirUp), .stb(stb), .mode(mode), .com(com),
    .blocked(blocked), .pinEnable(pinEnable)
  );

  tmrDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .cnt(cntVal),
    .ocr(ocrVal), .isMatch(isMatch), .atTop(atTop), .atBottom(atBottom),
    .dirUp(dirUp), .flag(cmpFlag), .ocLevel(ocLevel)
  );

  assign wavePin = pinEnable && ocLevel;

  logic cntWrIn, forceIn;
  assign cntWrIn = wrEn && (wrAddr == ADDR_CNT);
  assign forceIn = wrEn && (wrAddr == ADDR_FORCE) && wrData[0];

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cntWrIn) |=> $stable(cntVal));

  p_flag_src_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpFlag) |-> $past(tickEn && !cntWrIn && isMatch && !blocked));

  p_ctc_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_CTC && tickEn && !cntWrIn && isMatch && !blocked) |=> (cntVal == '0));

  p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1] && !(tickEn && !cntWrIn && atTop)) |=> $stable(ocrVal));

  p_pwm_force_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1] && forceIn && !tickEn) |=> $stable(wavePin));

  p_phase_turn_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PHASE && tickEn && !cntWrIn && atTop) |=> (cntVal == CNT_TURN));
endmodule

// File: tb/sim_tmrCompare.sv
module sim_tmrCompare;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic       wavePin, cmpFlag;
  logic [7:0] cntVal;

  int nChk = 0;
  int nFail = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tmrCompare #(.CNT_W(8)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wavePin(wavePin), .cmpFlag(cmpFlag), .cntVal(cntVal)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic t);
    tickEn = t;
    wrEn = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    tickEn = 1'b0;
    wrEn = 1'b1;
    wrAddr = a;
    wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic setCtrl(input logic [1:0] m, input logic [1:0] c);
    wr(3'd2, {4'b0000, m, c});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    int e, hi, kk;
    int kList[5];
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    check("R1 count after reset", int'(cntVal), 0);
    check("R1 pin after reset", int'(wavePin), 0);
    check("R1 flag after reset", int'(cmpFlag), 0);
    setCtrl(2'b00, 2'b11);
    check("R1 pin register zero", int'(wavePin), 0);

    // R2: normal counting with an irregular tick pattern
    setCtrl(2'b00, 2'b00);
    wr(3'd0, 8'd0);
    e = 0;
    for (int i = 0; i < 600; i++) begin
      step(i % 3 != 2);
      if (i % 3 != 2) e = (e + 1) % 256;
      check("R2 normal count", int'(cntVal), e);
    end

    // R3: flag set on match, cleared by write-one
    kList = '{1, 17, 128, 200, 255};
    foreach (kList[j]) begin
      kk = kList[j];
      wr(3'd1, 8'(kk));
      wr(3'd0, 8'd0);
      wr(3'd4, 8'd1);
      ticks(kk);
      check("R3 no flag before match", int'(cmpFlag), 0);
      check("R3 count at match", int'(cntVal), kk);
      step(1'b1);
      check("R3 flag after match", int'(cmpFlag), 1);
      wr(3'd4, 8'd0);
      check("R3 zero write keeps flag", int'(cmpFlag), 1);
      wr(3'd4, 8'd1);
      check("R3 flag cleared", int'(cmpFlag), 0);
    end

    // R4: clear-on-match period K+1
    kList = '{1, 2, 7, 100, 255};
    foreach (kList[j]) begin
      kk = kList[j];
      setCtrl(2'b01, 2'b00);
      wr(3'd1, 8'(kk));
      wr(3'd0, 8'd0);
      for (int n = 1; n <= 3 * (kk + 1); n++) begin
        step(1'b1);
        check("R4 ctc count", int'(cntVal), n % (kk + 1));
      end
    end

    // R5 / R12: non-PWM output actions
    setCtrl(2'b00, 2'b10);
    wr(3'd3, 8'd1);
    wr(3'd1, 8'h30);
    setCtrl(2'b00, 2'b01);
    wr(3'd0, 8'd0);
    ticks(8'h30);
    check("R5 toggle before match", int'(wavePin), 0);
    step(1'b1);
    check("R5 toggle on match", int'(wavePin), 1);
    ticks(255);
    check("R5 toggle holds", int'(wavePin), 1);
    step(1'b1);
    check("R5 toggle again", int'(wavePin), 0);
    setCtrl(2'b00, 2'b11);
    wr(3'd0, 8'd0);
    ticks(8'h31);
    check("R5 set on match", int'(wavePin), 1);
    setCtrl(2'b00, 2'b10);
    wr(3'd0, 8'd0);
    ticks(8'h31);
    check("R5 clear on match", int'(wavePin), 0);
    setCtrl(2'b00, 2'b11);
    wr(3'd3, 8'd1);
    setCtrl(2'b00, 2'b00);
    check("R12 disconnect at once", int'(wavePin), 0);
    wr(3'd0, 8'd0);
    ticks(8'h31);
    setCtrl(2'b00, 2'b01);
    check("R5 disconnected match left register", int'(wavePin), 1);

    // R6: immediate compare write in normal mode
    setCtrl(2'b00, 2'b00);
    wr(3'd1, 8'd20);
    wr(3'd0, 8'd0);
    wr(3'd4, 8'd1);
    ticks(10);
    wr(3'd1, 8'd12);
    ticks(2);
    check("R6 direct write no early flag", int'(cmpFlag), 0);
    step(1'b1);
    check("R6 direct write match", int'(cmpFlag), 1);

    // R6: buffered compare write in fast PWM
    setCtrl(2'b10, 2'b10);
    wr(3'd1, 8'd40);
    wr(3'd0, 8'd255);
    step(1'b1);
    hi = int'(wavePin);
    for (int i = 1; i < 256; i++) begin
      if (i == 100) wr(3'd1, 8'd200);
      step(1'b1);
      hi += int'(wavePin);
    end
    check("R6 buffered period unchanged", hi, 41);
    step(1'b1);
    hi = int'(wavePin);
    for (int i = 1; i < 256; i++) begin
      step(1'b1);
      hi += int'(wavePin);
    end
    check("R6 buffered value next period", hi, 201);

    // R9: fast PWM duty sweep
    for (int c = 2; c <= 3; c++) begin
      for (int k = 0; k < 256; k += (c == 2 ? 3 : 15)) begin
        setCtrl(2'b10, 2'(c));
        wr(3'd1, 8'(k));
        wr(3'd0, 8'd255);
        step(1'b1);
        hi = int'(wavePin);
        for (int i = 1; i < 256; i++) begin
          step(1'b1);
          hi += int'(wavePin);
        end
        if (c == 2) check("R9 fast non-inverting duty", hi, (k == 255) ? 256 : k + 1);
        else        check("R9 fast inverting duty", hi, (k == 255) ? 0 : 255 - k);
      end
    end

    // R10: phase-correct duty sweep
    for (int c = 2; c <= 3; c++) begin
      for (int k = 0; k < 256; k += 15) begin
        setCtrl(2'b11, 2'(c));
        wr(3'd1, 8'(k));
        wr(3'd0, 8'd255);
        step(1'b1);
        ticks(509);
        step(1'b1);
        check("R10 turn at top", int'(cntVal), 254);
        hi = int'(wavePin);
        for (int i = 1; i < 510; i++) begin
          step(1'b1);
          hi += int'(wavePin);
        end
        if (c == 2) check("R10 phase non-inverting duty", hi, 2 * k);
        else        check("R10 phase inverting duty", hi, 510 - 2 * k);
      end
    end

    // R7 / R11: force strobe
    setCtrl(2'b00, 2'b10);
    wr(3'd3, 8'd1);
    wr(3'd0, 8'd77);
    wr(3'd4, 8'd1);
    setCtrl(2'b00, 2'b11);
    wr(3'd3, 8'd1);
    check("R7 force set pin", int'(wavePin), 1);
    check("R7 force no flag", int'(cmpFlag), 0);
    check("R7 force keeps count", int'(cntVal), 77);
    setCtrl(2'b00, 2'b01);
    wr(3'd3, 8'd1);
    check("R7 force toggle", int'(wavePin), 0);
    wr(3'd3, 8'd1);
    check("R7 force toggle back", int'(wavePin), 1);
    setCtrl(2'b01, 2'b10);
    wr(3'd1, 8'd77);
    wr(3'd3, 8'd1);
    check("R7 force clear in ctc", int'(wavePin), 0);
    check("R7 ctc force keeps count", int'(cntVal), 77);
    check("R7 ctc force no flag", int'(cmpFlag), 0);
    setCtrl(2'b01, 2'b01);
    wr(3'd3, 8'd0);
    check("R7 force bit zero ignored", int'(wavePin), 0);
    setCtrl(2'b00, 2'b11);
    wr(3'd3, 8'd1);
    setCtrl(2'b10, 2'b10);
    check("R11 pin kept over mode change", int'(wavePin), 1);
    wr(3'd3, 8'd1);
    check("R7 force ignored in fast pwm", int'(wavePin), 1);
    check("R7 pwm force keeps count", int'(cntVal), 77);
    setCtrl(2'b11, 2'b10);
    wr(3'd3, 8'd1);
    check("R7 force ignored in phase pwm", int'(wavePin), 1);
    setCtrl(2'b00, 2'b10);
    wr(3'd3, 8'd1);
    setCtrl(2'b11, 2'b10);
    check("R11 cleared pin kept into phase mode", int'(wavePin), 0);

    // R8: counter write masks the next tick's match
    setCtrl(2'b00, 2'b00);
    wr(3'd1, 8'd5);
    wr(3'd4, 8'd1);
    wr(3'd0, 8'd5);
    step(1'b0);
    step(1'b0);
    step(1'b0);
    step(1'b1);
    check("R8 masked match no flag", int'(cmpFlag), 0);
    check("R8 masked tick still counts", int'(cntVal), 6);
    wr(3'd0, 8'd4);
    step(1'b1);
    check("R8 count after masked tick", int'(cntVal), 5);
    step(1'b1);
    check("R8 later match flagged", int'(cmpFlag), 1);
    setCtrl(2'b01, 2'b00);
    wr(3'd1, 8'd9);
    wr(3'd4, 8'd1);
    wr(3'd0, 8'd9);
    step(1'b1);
    check("R8 ctc masked no clear", int'(cntVal), 10);
    check("R8 ctc masked no flag", int'(cmpFlag), 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule